// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working-register storage of a small 8-bit CPU that keeps program and data memories apart. It holds a bank of byte registers with two combinational operand read ports and one synchronous result write port, so an ALU can read two operands and write the result back in a single clock cycle. The top six registers also act as three 16-bit address pointers, called X, Y and Z. Each pointer can be read as a whole word and loaded as a whole word in one edge. An address unit uses this for post-increment and pre-decrement addressing, and Z also serves as the table-lookup address into program memory.

The same registers are visible at the lowest addresses of the linear data space through a separate memory-mapped port. Loads and stores whose address falls inside that window read or write a register. Any other address raises a not-selected flag, so the data-space fabric can route the access to the I/O registers from 0x20 upward or to SRAM. The block holds only storage, pointer views and this window. It has no handshake: every access completes in its cycle, so no port ever applies back-pressure.

Top module: `rf_pointer_file`

## Requirements
- R1: The block holds 32 registers of 8 bits each. A byte write with `wr_en` high stores `wr_data` into register `wr_idx` at the next rising edge, and both read ports see the new value after that edge.
- R2: The two read ports are combinational and independent: `rd_a_data` always shows register `rd_a_idx` and `rd_b_data` shows register `rd_b_idx`, in the same cycle the index is applied.
- R3: There is no write-through bypass. A read of a register that is being written in the same cycle returns the value it held before the edge.
- R4: The pointer outputs are X = {r27, r26}, Y = {r29, r28} and Z = {r31, r30}, with the even register as the low byte. `ptr_z` is also the program-memory table address.
- R5: With `ptr_we` high, `ptr_sel` picks the pointer (0 = X, 1 = Y, 2 = Z). Both bytes of the chosen pair take `ptr_wdata` at the same edge.
- R6: A pointer write with `ptr_sel` = 3 changes no register.
- R7: When a pointer write and a byte write hit the same register in one cycle, the pointer value is stored. A byte write to a register outside the selected pair still takes effect in that cycle.
- R8: When `ds_addr[15:5]` is zero, `ds_miss` is 0 and `ds_rdata` shows register `ds_addr[4:0]`. For any other address, `ds_miss` is 1 and `ds_rdata` is 0.
- R9: A data-space store (`ds_we`) writes `ds_wdata` only when the address is inside the window and is ignored otherwise. On the same register it has lower priority than both the byte write and the pointer write.
- R10: A synchronous active-high `rst` clears every register to zero at the next edge and overrides every write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | Byte result write enable |
| wr_idx | input | 5 | Byte result register index |
| wr_data | input | 8 | Byte result value |
| ptr_we | input | 1 | Pointer word write enable |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Pointer word value |
| ptr_x | output | 16 | X pointer {r27, r26} |
| ptr_y | output | 16 | Y pointer {r29, r28} |
| ptr_z | output | 16 | Z pointer {r31, r30}, also table address |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space store enable |
| ds_wdata | input | 8 | Data-space store value |
| ds_rdata | output | 8 | Data-space load value, 0 on a miss |
| ds_miss | output | 1 | Address lies outside the register window |

## Verification
The assertions take for granted that the enables, `ptr_sel` and all indices carry known values once reset has been released. They also assume that `rst` is held for at least one edge before any property is evaluated. The bench changes every input only at the falling edge and keeps indices inside their 5-bit range. It applies all four `ptr_sel` codes and addresses on both sides of the window boundary. A pseudo-random phase then stacks byte, pointer and data-space writes onto the same registers, so the priority rules are exercised together rather than one at a time.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Pointer selection codes used on ptr_sel.
  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } ptr_sel_e;

  // Number of register pairs that serve as pointers.
  localparam int unsigned PTR_PAIRS = 3;
endpackage

// File: rtl/rf_dspace_decode.sv
// Maps a data-space address onto the register window at the bottom of the map.
module rf_dspace_decode #(
  parameter int unsigned AW   = 16,
  parameter int unsigned IDXW = 5
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  assign hit = (addr[AW-1:IDXW] == '0);
  assign idx = addr[IDXW-1:0];
endmodule

// File: rtl/rf_ptr_decode.sv
// Turns a pointer word write into per-register strobes and byte lanes.
module rf_ptr_decode
  import rf_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8
) (
  input  logic            ptr_we,
  input  logic [1:0]      ptr_sel,
  input  logic [2*DW-1:0] ptr_wdata,
  output logic [NREG-1:0] pw_hit,
  output logic [DW-1:0]   pw_lo,
  output logic [DW-1:0]   pw_hi
);
  localparam int unsigned PTR_BASE = NREG - 2 * PTR_PAIRS;

  ptr_sel_e sel;
  assign sel   = ptr_sel_e'(ptr_sel);
  assign pw_lo = ptr_wdata[DW-1:0];
  assign pw_hi = ptr_wdata[2*DW-1:DW];

  always_comb begin
    pw_hit = '0;
    for (int p = 0; p < int'(PTR_PAIRS); p++) begin
      if (ptr_we && (sel != PSEL_NONE) && (int'(sel) == p)) begin
        pw_hit[PTR_BASE + 2*p]     = 1'b1;
        pw_hit[PTR_BASE + 2*p + 1] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_cell.sv
// One byte register with a fixed write priority: reset, pointer, byte, store.
module rf_cell #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_hit,
  input  logic [DW-1:0] ptr_byte,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_byte,
  input  logic          ds_hit,
  input  logic [DW-1:0] ds_byte,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (ptr_hit) q <= ptr_byte;
    else if (wr_hit)  q <= wr_byte;
    else if (ds_hit)  q <= ds_byte;
  end
endmodule

// File: rtl/rf_pointer_file.sv
// Register bank with pointer-pair views and a data-space window.
module rf_pointer_file
  import rf_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  output logic [DW-1:0]           rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [DW-1:0]           rd_b_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ptr_we,
  input  logic [1:0]              ptr_sel,
  input  logic [2*DW-1:0]         ptr_wdata,
  output logic [2*DW-1:0]         ptr_x,
  output logic [2*DW-1:0]         ptr_y,
  output logic [2*DW-1:0]         ptr_z,
  input  logic [AW-1:0]           ds_addr,
  input  logic                    ds_we,
  input  logic [DW-1:0]           ds_wdata,
  output logic [DW-1:0]           ds_rdata,
  output logic                    ds_miss
);
  localparam int unsigned IDXW     = $clog2(NREG);
  localparam int unsigned PTR_BASE = NREG - 2 * PTR_PAIRS;

  logic [DW-1:0]   regs [NREG];
  logic [NREG-1:0] pw_hit;
  logic [DW-1:0]   pw_lo, pw_hi;
  logic            ds_hit;
  logic [IDXW-1:0] ds_idx;

  rf_ptr_decode #(.NREG(NREG), .DW(DW)) u_ptr_dec (
    .ptr_we    (ptr_we),
    .ptr_sel   (ptr_sel),
    .ptr_wdata (ptr_wdata),
    .pw_hit    (pw_hit),
    .pw_lo     (pw_lo),
    .pw_hi     (pw_hi)
  );

  rf_dspace_decode #(.AW(AW), .IDXW(IDXW)) u_ds_dec (
    .addr (ds_addr),
    .hit  (ds_hit),
    .idx  (ds_idx)
  );

  for (genvar i = 0; i < int'(NREG); i++) begin : g_reg
    logic          wr_sel, ds_sel;
    logic [DW-1:0] lane;
    assign wr_sel = wr_en && (wr_idx == IDXW'(i));
    assign ds_sel = ds_we && ds_hit && (ds_idx == IDXW'(i));
    if (i % 2 == 0) begin : g_even
      assign lane = pw_lo;
    end else begin : g_odd
      assign lane = pw_hi;
    end
    rf_cell #(.DW(DW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .ptr_hit  (pw_hit[i]),
      .ptr_byte (lane),
      .wr_hit   (wr_sel),
      .wr_byte  (wr_data),
      .ds_hit   (ds_sel),
      .ds_byte  (ds_wdata),
      .q        (regs[i])
    );
  end

  // Operand reads: plain muxes, no bypass from the write port.
  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  // Pointer views, even register is the low byte.
  assign ptr_x = {regs[PTR_BASE + 1], regs[PTR_BASE + 0]};
  assign ptr_y = {regs[PTR_BASE + 3], regs[PTR_BASE + 2]};
  assign ptr_z = {regs[PTR_BASE + 5], regs[PTR_BASE + 4]};

  // Data-space window.
  assign ds_rdata = ds_hit ? regs[ds_idx] : '0;
  assign ds_miss  = !ds_hit;
endmodule

// File: rtl/rf_pointer_file_chk.sv
module rf_pointer_file_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [$clog2(NREG)-1:0] rd_a_idx,
  input logic [DW-1:0]           rd_a_data,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [DW-1:0]           wr_data,
  input logic                    ptr_we,
  input logic [1:0]              ptr_sel,
  input logic [2*DW-1:0]         ptr_wdata,
  input logic [2*DW-1:0]         ptr_x,
  input logic [2*DW-1:0]         ptr_y,
  input logic [2*DW-1:0]         ptr_z,
  input logic [AW-1:0]           ds_addr,
  input logic                    ds_we,
  input logic [DW-1:0]           ds_rdata,
  input logic                    ds_miss
);
  localparam int unsigned IDXW   = $clog2(NREG);
  localparam int unsigned X_LO   = NREG - 6;
  localparam int unsigned Z_LO   = NREG - 2;

  // R1
  byte_to_x_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDXW'(X_LO) && !ptr_we) |=> (ptr_x[DW-1:0] == $past(wr_data)));

  // R5
  ptr_x_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_we && ptr_sel == 2'd0) |=> (ptr_x == $past(ptr_wdata)));

  // R5
  ptr_y_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_we && ptr_sel == 2'd1) |=> (ptr_y == $past(ptr_wdata)));

  // R6
  ptr_none_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_we && ptr_sel == 2'd3 && !wr_en && !ds_we) |=>
      ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

  // R7
  ptr_over_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_we && ptr_sel == 2'd2 && wr_en && wr_idx == IDXW'(Z_LO)) |=> (ptr_z == $past(ptr_wdata)));

  // R8
  ds_miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ds_miss |-> (ds_rdata == '0));

  // R8
  ds_view_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!ds_miss && rd_a_idx == ds_addr[IDXW-1:0]) |-> (ds_rdata == rd_a_data));

  // R9
  ds_miss_store_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_we && ds_miss && !wr_en && !ptr_we) |=>
      ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));
endmodule

bind rf_pointer_file rf_pointer_file_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/rf_pointer_file_bench.sv
`timescale 1ns/1ps
module rf_pointer_file_bench;
  typedef struct {
    int          which;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0, ds_wdata = '0, ds_rdata;
  logic        wr_en = 1'b0, ptr_we = 1'b0, ds_we = 1'b0, ds_miss;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] ptr_wdata = '0, ptr_x, ptr_y, ptr_z, ds_addr = '0;

  item_t       sb[$];
  logic [7:0]  m [32];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rf_pointer_file u_rf_pointer_file (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_miss(ds_miss)
  );

  function automatic logic [15:0] actual(int which);
    case (which)
      0: return {8'h00, rd_a_data};
      1: return {8'h00, rd_b_data};
      2: return ptr_x;
      3: return ptr_y;
      4: return ptr_z;
      5: return {8'h00, ds_rdata};
      default: return {15'h0, ds_miss};
    endcase
  endfunction

  function automatic string port_name(int which);
    case (which)
      0: return "rd_a_data";
      1: return "rd_b_data";
      2: return "ptr_x";
      3: return "ptr_y";
      4: return "ptr_z";
      5: return "ds_rdata";
      default: return "ds_miss";
    endcase
  endfunction

  function automatic void push(int which, logic [15:0] exp, string tag);
    item_t it;
    it.which = which;
    it.exp   = exp;
    it.tag   = tag;
    sb.push_back(it);
  endfunction

  // Driver: applies one cycle of stimulus, queues the expected outputs, updates the model.
  task automatic step(input logic r, input logic we, input logic [4:0] wi, input logic [7:0] wd,
                      input logic pwe, input logic [1:0] ps, input logic [15:0] pd,
                      input logic [15:0] da, input logic dwe, input logic [7:0] dwd,
                      input logic [4:0] ra, input logic [4:0] rb, input string tag);
    logic hit;
    @(negedge clk);
    rst = r; wr_en = we; wr_idx = wi; wr_data = wd;
    ptr_we = pwe; ptr_sel = ps; ptr_wdata = pd;
    ds_addr = da; ds_we = dwe; ds_wdata = dwd;
    rd_a_idx = ra; rd_b_idx = rb;
    hit = (da[15:5] == 11'h0);
    push(0, {8'h00, m[ra]}, tag);
    push(1, {8'h00, m[rb]}, tag);
    push(2, {m[27], m[26]}, tag);
    push(3, {m[29], m[28]}, tag);
    push(4, {m[31], m[30]}, tag);
    push(5, hit ? {8'h00, m[da[4:0]]} : 16'h0, tag);
    push(6, {15'h0, !hit}, tag);
    if (dwe && hit) m[da[4:0]] = dwd;
    if (we) m[wi] = wd;
    if (pwe && ps != 2'd3) begin
      m[26 + 2*int'(ps)] = pd[7:0];
      m[27 + 2*int'(ps)] = pd[15:8];
    end
    if (r) for (int k = 0; k < 32; k++) m[k] = 8'h00;
  endtask

  task automatic rd(input logic [4:0] ra, input logic [4:0] rb, input logic [15:0] da, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, da, 0, 0, ra, rb, tag);
  endtask

  // Monitor: compares queued expectations well after the inputs settle.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb.pop_front();
        act = actual(it.which);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: %s actual %h expected %h", it.tag, port_name(it.which), act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < 32; k++) m[k] = 8'h00;
    repeat (2) @(negedge clk);
    // R10: reset overrides a byte, pointer and store in the same cycle
    step(1, 1, 5'd3, 8'hAA, 1, 2'd0, 16'h1234, 16'h0004, 1, 8'h55, 0, 0, "R10 reset beats writes");
    rd(5'd3, 5'd26, 16'h0004, "R10 reset state");
    rd(5'd27, 5'd4, 16'h001F, "R10 reset state");
    // R1 and R2: byte writes, then independent reads
    step(0, 1, 5'd0, 8'h11, 0, 0, 0, 16'h0000, 0, 0, 0, 0, "R1 write r0");
    step(0, 1, 5'd17, 8'hC3, 0, 0, 0, 16'h0000, 0, 0, 0, 0, "R1 write r17");
    rd(5'd0, 5'd17, 16'h0011, "R2 dual read");
    rd(5'd17, 5'd0, 16'h0000, "R2 swapped read");
    // R3: read of the register being written sees the old value
    step(0, 1, 5'd17, 8'h3C, 0, 0, 0, 16'h0011, 0, 0, 5'd17, 5'd17, "R3 no bypass");
    rd(5'd17, 5'd0, 16'h0011, "R3 new value next cycle");
    // R4: pointer views assembled from byte writes
    step(0, 1, 5'd26, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r26");
    step(0, 1, 5'd27, 8'h80, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r27");
    step(0, 1, 5'd28, 8'h02, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r28");
    step(0, 1, 5'd29, 8'h90, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r29");
    step(0, 1, 5'd30, 8'h03, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r30");
    step(0, 1, 5'd31, 8'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 r31");
    rd(5'd26, 5'd31, 16'h001E, "R4 pointer views");
    // R5: whole-word pointer loads
    step(0, 0, 0, 0, 1, 2'd0, 16'hBEEF, 0, 0, 0, 0, 0, "R5 load X");
    step(0, 0, 0, 0, 1, 2'd1, 16'hCAFE, 0, 0, 0, 0, 0, "R5 load Y");
    step(0, 0, 0, 0, 1, 2'd2, 16'hF00D, 0, 0, 0, 0, 0, "R5 load Z");
    rd(5'd26, 5'd27, 16'h001F, "R5 pointer bytes");
    // R6: select code 3 changes nothing
    step(0, 0, 0, 0, 1, 2'd3, 16'h5A5A, 0, 0, 0, 0, 0, "R6 no pointer");
    rd(5'd30, 5'd31, 16'h001A, "R6 unchanged");
    // R7: pointer write wins on the shared register, other byte write lands
    step(0, 1, 5'd31, 8'h77, 1, 2'd2, 16'h1357, 0, 0, 0, 0, 0, "R7 Z beats r31");
    step(0, 1, 5'd5, 8'h66, 1, 2'd1, 16'h2468, 0, 0, 0, 0, 0, "R7 disjoint");
    rd(5'd5, 5'd31, 16'h0005, "R7 result");
    // R8: window boundary and far addresses
    rd(5'd0, 5'd1, 16'h001F, "R8 top of window");
    rd(5'd0, 5'd1, 16'h0020, "R8 first I/O address");
    rd(5'd0, 5'd1, 16'h8000, "R8 high address");
    rd(5'd0, 5'd1, 16'h0100, "R8 mid address");
    // R9: stores inside and outside the window, and priority against byte writes
    step(0, 0, 0, 0, 0, 0, 0, 16'h0009, 1, 8'h99, 0, 0, "R9 store hit");
    step(0, 0, 0, 0, 0, 0, 0, 16'h0029, 1, 8'h42, 0, 0, "R9 store miss");
    step(0, 1, 5'd12, 8'hE1, 0, 0, 0, 16'h000C, 1, 8'h1E, 0, 0, "R9 byte beats store");
    step(0, 0, 0, 0, 1, 2'd0, 16'h4321, 16'h001A, 1, 8'hFF, 0, 0, "R9 pointer beats store");
    rd(5'd9, 5'd12, 16'h0009, "R9 result");
    rd(5'd26, 5'd27, 16'h0029, "R9 miss ignored");
    // Mixed pseudo-random traffic over all ports
    lf = 16'hACE1;
    for (int n = 0; n < 120; n++) begin
      logic [15:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b  = lf;
      step(0, a[0], a[5:1], a[13:6], a[14], b[1:0], {b[7:0], a[15:8]},
           b[2] ? {11'h0, b[7:3]} : {b[15:8], 8'h20}, b[15], b[15:8],
           b[12:8], a[11:7], "R1 R5 R7 R9 mixed");
    end
    // R10: reset in the middle of traffic
    step(1, 1, 5'd7, 8'h12, 0, 0, 0, 0, 0, 0, 0, 0, "R10 mid reset");
    rd(5'd7, 5'd30, 16'h0007, "R10 cleared");
    @(negedge clk);
    @(negedge clk);
    #8;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule